// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit sits beside an SPI shift engine and its receive and transmit FIFOs. Each clock it looks at the two FIFO fill counts and at three one-cycle event pulses: receive overflow, transmit underrun and transfer complete. It turns them into six event conditions and latches each one into a sticky status bit. Software reads the status vector, services the FIFOs, and then writes the same value back. Every bit written as one is cleared. A status value of zero means nothing is pending.

A separate enable vector selects which latched events may raise the single interrupt line. The interrupt line is registered. It follows the OR of status AND enable, one clock later. Writing zero to the enable vector silences the line. Events still latch while they are masked, so software can poll the status vector.

Status bit positions are fixed, and both the enable vector and the clear mask use the same positions:

| Bit | Event |
|-----|-------|
| 0 | receive ready |
| 1 | receive half full |
| 2 | transmit half empty |
| 3 | receive overflow |
| 4 | transmit underrun |
| 5 | transfer complete |

Top module: `spi_irq_unit`

## Requirements
- R1: After a synchronous reset, the status vector, the enable vector and the interrupt line are all zero.
- R2: Status bit 0 (receive ready) is set one clock after any cycle in which the receive fill count is nonzero.
- R3: Status bit 1 (receive half full) is set one clock after any cycle in which the receive fill count is 32 or more, with a FIFO depth of 64.
- R4: Status bit 2 (transmit half empty) is set one clock after any cycle in which the transmit fill count is 32 or less.
- R5: A one-cycle pulse sets the matching status bit one clock later: bit 3 for receive overflow, bit 4 for transmit underrun, and bit 5 for transfer complete.
- R6: A status bit stays set after its condition goes away, whatever the enable setting, until a clear write removes it.
- R7: A clear write clears exactly those status bits whose mask bit is one and leaves the other bits unchanged. A mask of all ones clears every bit.
- R8: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: An enable write takes effect one clock later, and the enable vector reads back the written value.
- R10: The interrupt line equals the OR of (status AND enable) as it stood one clock earlier. With an enable of zero, the line stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W (7) | Receive FIFO fill count |
| tx_level | input | LVL_W (7) | Transmit FIFO fill count |
| rx_ovf | input | 1 | Receive overflow pulse |
| tx_udr | input | 1 | Transmit underrun pulse |
| xfer_done | input | 1 | Transfer complete pulse |
| en_we | input | 1 | Enable vector write strobe |
| en_wdata | input | 6 | New enable vector |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 6 | Clear mask, where a one clears that bit |
| status | output | 6 | Latched event status |
| enable | output | 6 | Current enable vector |
| irq | output | 1 | Interrupt request |

## Verification
The receive fill count is swept over every value from 0 to 64, and the transmit fill count likewise. These two sweeps locate the exact edges of the ready, half-full and half-empty thresholds. Each pulse input is fired on its own and then held off for several cycles, which separates sticky latching from a bit that merely follows its input. All 64 clear masks are applied to a fully set status, which shows that clearing is per bit. For each of the 64 enable values, the status vector is set to a different pattern and the interrupt line is compared with the arithmetic OR of the overlap. A clear that collides with a completion pulse checks that the event wins.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_EV        = 6;
  localparam int EV_RX_RDY     = 0;
  localparam int EV_RX_HALF    = 1;
  localparam int EV_TX_HALFEMP = 2;
  localparam int EV_RX_OVF     = 3;
  localparam int EV_TX_UDR     = 4;
  localparam int EV_XFER_DONE  = 5;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/spi_irq_detect.sv
// Turns FIFO fill counts and event pulses into a per-cycle event vector.
module spi_irq_detect
  import spi_irq_pkg::*;
#(
  parameter int LVL_W      = 7,
  parameter int RX_HALF_TH = 32,
  parameter int TX_HALF_TH = 32
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             rx_ovf,
  input  logic             tx_udr,
  input  logic             xfer_done,
  output ev_vec_t          ev
);
  localparam logic [LVL_W-1:0] RX_TH = LVL_W'(RX_HALF_TH);
  localparam logic [LVL_W-1:0] TX_TH = LVL_W'(TX_HALF_TH);

  always_comb begin
    ev                = '0;
    ev[EV_RX_RDY]     = (rx_level != '0);
    ev[EV_RX_HALF]    = (rx_level >= RX_TH);
    ev[EV_TX_HALFEMP] = (tx_level <= TX_TH);
    ev[EV_RX_OVF]     = rx_ovf;
    ev[EV_TX_UDR]     = tx_udr;
    ev[EV_XFER_DONE]  = xfer_done;
  end
endmodule

// File: rtl/spi_irq_status.sv
// Sticky status register: set on event, cleared by write-one, set wins.
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ev_vec_t ev,
  input  logic    clr_we,
  input  ev_vec_t clr_mask,
  output ev_vec_t status_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    logic clr_bit;
    assign clr_bit = clr_we & clr_mask[i];
    always_ff @(posedge clk) begin
      if (rst)        status_q[i] <= 1'b0;
      else if (ev[i]) status_q[i] <= 1'b1;
      else if (clr_bit) status_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_gate.sv
// Enable register and registered interrupt output.
module spi_irq_gate
  import spi_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en_we,
  input  ev_vec_t en_wdata,
  input  ev_vec_t status_q,
  output ev_vec_t enable_q,
  output logic    irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (en_we) enable_q <= en_wdata;
      irq_q <= |(status_q & enable_q);
    end
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int RX_HALF_TH = FIFO_DEPTH / 2,
  parameter int TX_HALF_TH = FIFO_DEPTH / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [LVL_W-1:0]    tx_level,
  input  logic                rx_ovf,
  input  logic                tx_udr,
  input  logic                xfer_done,
  input  logic                en_we,
  input  logic [NUM_EV-1:0]   en_wdata,
  input  logic                clr_we,
  input  logic [NUM_EV-1:0]   clr_wdata,
  output logic [NUM_EV-1:0]   status,
  output logic [NUM_EV-1:0]   enable,
  output logic                irq
);
  ev_vec_t ev;
  ev_vec_t status_q;
  ev_vec_t enable_q;
  logic    irq_q;

  spi_irq_detect #(
    .LVL_W(LVL_W), .RX_HALF_TH(RX_HALF_TH), .TX_HALF_TH(TX_HALF_TH)
  ) detect_i (
    .rx_level(rx_level), .tx_level(tx_level), .rx_ovf(rx_ovf),
    .tx_udr(tx_udr), .xfer_done(xfer_done), .ev(ev)
  );

  spi_irq_status status_i (
    .clk(clk), .rst(rst), .ev(ev), .clr_we(clr_we),
    .clr_mask(clr_wdata), .status_q(status_q)
  );

  spi_irq_gate gate_i (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
    .status_q(status_q), .enable_q(enable_q), .irq_q(irq_q)
  );

  assign status = status_q;
  assign enable = enable_q;
  assign irq    = irq_q;
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
  import spi_irq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_ovf,
  input logic              xfer_done,
  input logic              en_we,
  input logic [NUM_EV-1:0] en_wdata,
  input logic              clr_we,
  input logic [NUM_EV-1:0] clr_wdata,
  input logic [NUM_EV-1:0] status,
  input logic [NUM_EV-1:0] enable,
  input logic              irq
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic [NUM_EV-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_wdata : '0;

  // R1
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) && past_ok == 1'b0 && !rst |-> (status == '0 && enable == '0 && !irq));

  // R2
  rx_ready_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rx_level != '0) |-> status[EV_RX_RDY]);

  // R5
  ovf_latch_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rx_ovf) |-> status[EV_RX_OVF]);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(status) & ~$past(clr_eff) & ~status) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(xfer_done && clr_we && clr_wdata[EV_XFER_DONE]) |-> status[EV_XFER_DONE]);

  // R9
  enable_wr_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(en_we) |-> enable == $past(en_wdata));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> irq == $past(|(status & enable)));
endmodule

bind spi_irq_unit spi_irq_unit_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .rx_level(rx_level), .rx_ovf(rx_ovf),
  .xfer_done(xfer_done), .en_we(en_we), .en_wdata(en_wdata),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .status(status),
  .enable(enable), .irq(irq)
);

// File: tb/spi_irq_unit_tb_top.sv
`timescale 1ns/1ps
module spi_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] rx_level, tx_level;
  logic       rx_ovf, tx_udr, xfer_done;
  logic       en_we, clr_we;
  logic [5:0] en_wdata, clr_wdata;
  logic [5:0] status, enable;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_irq_unit dut_i (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_ovf(rx_ovf), .tx_udr(tx_udr), .xfer_done(xfer_done),
    .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .status(status), .enable(enable), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic neutral();
    rx_level = 7'd0; tx_level = 7'd64;
    rx_ovf = 1'b0; tx_udr = 1'b0; xfer_done = 1'b0;
    en_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_wdata = 6'h3F;
    tick();
    clr_we = 1'b0;
  endtask

  task automatic set_all();
    rx_level = 7'd64; tx_level = 7'd0;
    rx_ovf = 1'b1; tx_udr = 1'b1; xfer_done = 1'b1;
    tick();
  endtask

  initial begin
    neutral();
    en_wdata = '0; clr_wdata = '0;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1
    chk("R1 status", status, 0);
    chk("R1 enable", enable, 0);
    chk("R1 irq", irq, 0);

    // R2 / R3: receive count sweep
    for (int v = 0; v <= 64; v++) begin
      rx_level = 7'(v);
      tick();
      rx_level = 7'd0;
      chk("R2 rx ready", status[0], (v != 0) ? 1 : 0);
      chk("R3 rx half", status[1], (v >= 32) ? 1 : 0);
      clear_all();
    end

    // R4: transmit count sweep
    for (int v = 0; v <= 64; v++) begin
      tx_level = 7'(v);
      tick();
      tx_level = 7'd64;
      chk("R4 tx half empty", status, (v <= 32) ? 32'h4 : 32'h0);
      clear_all();
    end

    // R5 / R6: pulses latch and stick
    for (int b = 3; b <= 5; b++) begin
      rx_ovf = (b == 3); tx_udr = (b == 4); xfer_done = (b == 5);
      tick();
      rx_ovf = 1'b0; tx_udr = 1'b0; xfer_done = 1'b0;
      chk("R5 pulse latch", status, 1 << b);
      repeat (4) tick();
      chk("R6 sticky", status, 1 << b);
      chk("R10 masked irq", irq, 0);
      clear_all();
      chk("R7 clear all", status, 0);
    end

    // R7: every clear mask
    for (int p = 0; p < 64; p++) begin
      set_all();
      neutral();
      chk("R7 set all", status, 6'h3F);
      clr_we = 1'b1; clr_wdata = 6'(p);
      tick();
      clr_we = 1'b0;
      chk("R7 selective clear", status, (~p) & 6'h3F);
      clear_all();
    end

    // R8: event wins over same-cycle clear
    clear_all();
    xfer_done = 1'b1; clr_we = 1'b1; clr_wdata = 6'h3F;
    tick();
    xfer_done = 1'b0; clr_we = 1'b0;
    chk("R8 set wins", status, 6'h20);
    clear_all();

    // R9 / R10: enable sweep against varied status patterns
    for (int e = 0; e < 64; e++) begin
      automatic int s = (e * 13 + 5) & 6'h3F;
      set_all();
      neutral();
      clr_we = 1'b1; clr_wdata = 6'(~s);
      en_we = 1'b1; en_wdata = 6'(e);
      tick();
      clr_we = 1'b0; en_we = 1'b0;
      chk("R9 enable readback", enable, e);
      chk("R6 status pattern", status, s);
      tick();
      chk("R10 irq", irq, ((e & s) != 0) ? 1 : 0);
      clear_all();
    end

    // R10: irq drops after clear
    tick();
    chk("R10 irq after clear", irq, 0);
    // R9: zero enable masks all
    en_we = 1'b1; en_wdata = 6'h00;
    tick();
    en_we = 1'b0;
    set_all();
    neutral();
    tick();
    chk("R9 zero enable irq", irq, 0);
    chk("R6 latched while masked", status, 6'h3F);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule